// File: doc/BRIEF.md
# Multi-Format Stereo PCM Serial Receiver

This block takes a three-wire stereo PCM stream: a bit clock, a word-select (frame) clock and a serial data line. All three are sampled in the system clock domain. Each bit-clock rising edge is one data slot. A change of the word-select level between two slots marks the boundary between half-frames. At each boundary the block completes the word of the half-frame that has just ended.

A two-bit format code selects the framing: 16-bit LSB-justified, 24-bit LSB-justified, 24-bit MSB-justified, or I2S-style with a one-slot delay. In the LSB-justified framings the word is the last bits before the boundary, so its position does not depend on the bit-clock ratio. In the other two framings the word starts at a fixed slot after the boundary.

Sixteen-bit words are placed at the top of the 24-bit outputs, with zeros below them. When a right-channel half-frame completes after a left one, both words are presented together with a one-cycle strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is low and `left_o` and `right_o` are zero until the first strobe.
- R2: Format code 00 (16-bit LSB-justified): the word is the 16 bits sampled on the last 16 bit-clock rising edges before the word-select change, MSB first. It is output as {word, 8'h00}, at both 16 and 32 slots per half-frame.
- R3: Format code 01 (24-bit LSB-justified): the word is the 24 bits sampled on the last 24 rising edges before the word-select change. Earlier slots have no effect. This holds at 24 and 32 slots per half-frame.
- R4: Format code 10 (MSB-justified): the MSB is the bit sampled on the first rising edge at the new word-select level. The next 23 bits follow it, and any later slots in the half-frame are ignored.
- R5: Format code 11 (I2S-style): the MSB is the bit sampled on the second rising edge of the half-frame, and bits beyond 24 are ignored. If the half-frame ends before 24 bits have arrived, the first bit of the following half-frame completes the word, and any positions still missing read as zero. At 16 slots per half-frame, a 16-bit word therefore appears as {word, 8'h00}.
- R6: For codes 00, 01 and 10, a word-select level of 1 marks the left half-frame. For code 11, a level of 0 marks the left half-frame.
- R7: `valid_o` pulses for exactly one cycle, carrying the left and right words of one frame. With the default two synchronizer stages, it rises exactly 3 clock cycles after the input clock edge at which the bit-clock rising edge that begins the next half-frame is applied. Between pulses, `left_o` and `right_o` hold their values.
- R8: After reset, and whenever `fmt_i` changes, the first word-select change only establishes alignment. No strobe is produced until a complete left half-frame and then a complete right half-frame have been received. A right half-frame without a preceding left one produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing code: 00 LSB16, 01 LSB24, 10 MSB24, 11 I2S-style |
| bck_i | input | 1 | Serial bit clock, asynchronous to clk_i |
| lrck_i | input | 1 | Word-select (frame) clock |
| sdat_i | input | 1 | Serial data, MSB first, two's complement |
| valid_o | output | 1 | One-cycle strobe when a stereo pair is complete |
| left_o | output | 24 | Left-channel word, 16-bit data left-aligned |
| right_o | output | 24 | Right-channel word, 16-bit data left-aligned |

## Verification
The bit-clock rising edge that opens the half-frame after a right channel is driven at a falling system-clock edge. It passes through two synchronizer flops, and the output register loads on the third rising clock edge. The strobe is therefore due at exactly the third falling edge after the stimulus. The reference model records that due cycle and expected pair at the moment it drives the edge. On every falling clock edge it requires the strobe to be present exactly when an entry is due, and it compares the words only then. On all other cycles it requires both output words to hold their last values.

// File: rtl/aser_pkg.sv
package aser_pkg;

   // Framing codes seen on fmt_i; the encoding is part of the port contract.
   typedef enum logic [1:0] {
      FMT_LSB16 = 2'b00,
      FMT_LSB24 = 2'b01,
      FMT_MSB24 = 2'b10,
      FMT_I2S   = 2'b11
   } aser_fmt_e;

endpackage

// File: rtl/aser_sync.sv
module aser_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end

         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/aser_front.sv
module aser_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bck_i,
   input  logic lrck_i,
   input  logic sdat_i,
   output logic bit_stb,
   output logic bit_lr,
   output logic bit_val
);

   logic [2:0] raw_in;
   logic [2:0] sync_out;
   logic       bck_s;
   logic       bck_prev_q;

   // All three wires share one synchronizer so their relative timing is kept.
   assign raw_in = {bck_i, lrck_i, sdat_i};

   aser_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign bck_s = sync_out[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bck_prev_q <= 1'b0;
      else        bck_prev_q <= bck_s;
   end

   // One slot per bit-clock rising edge.
   assign bit_stb = bck_s & ~bck_prev_q;
   assign bit_lr  = sync_out[1];
   assign bit_val = sync_out[0];

endmodule

// File: rtl/aser_deser.sv
module aser_deser
   import aser_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int SHORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  aser_fmt_e         fmt,
   input  logic              rearm,
   input  logic              bit_stb,
   input  logic              bit_lr,
   input  logic              bit_val,
   output logic              word_stb,
   output logic [DATA_W-1:0] word,
   output logic              word_lr
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam int PAD_W = DATA_W - SHORT_W;

   logic              lr_prev_q;
   logic              armed_q;
   logic [DATA_W-1:0] tail_q;    // last DATA_W bits seen
   logic [DATA_W-1:0] head_q;    // bits collected from the start of the half-frame
   logic [CNT_W-1:0]  head_cnt_q;
   logic [DATA_W-1:0] head_ins;
   logic [DATA_W-1:0] short_word;
   logic              boundary;
   logic              head_full;

   assign boundary  = bit_stb && (bit_lr != lr_prev_q);
   assign head_full = (int'(head_cnt_q) >= DATA_W);

   // Head register with the current bit placed at the next free position.
   always_comb begin
      head_ins = head_q;
      if (!head_full) head_ins[DATA_W-1-int'(head_cnt_q)] = bit_val;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign short_word = {tail_q[SHORT_W-1:0], {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign short_word = tail_q;
      end
   endgenerate

   always_comb begin
      unique case (fmt)
         FMT_LSB16: word = short_word;
         FMT_LSB24: word = tail_q;
         FMT_MSB24: word = head_q;
         default:   word = head_ins;   // delayed framing may take the boundary bit
      endcase
   end

   assign word_stb = boundary && armed_q && !rearm;
   assign word_lr  = lr_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_prev_q  <= 1'b0;
         armed_q    <= 1'b0;
         tail_q     <= '0;
         head_q     <= '0;
         head_cnt_q <= '0;
      end else begin
         if (rearm) begin
            armed_q <= 1'b0;
         end else if (boundary) begin
            armed_q <= 1'b1;
         end

         if (bit_stb) begin
            lr_prev_q <= bit_lr;
            tail_q    <= {tail_q[DATA_W-2:0], bit_val};
            if (boundary) begin
               if (fmt == FMT_I2S) begin
                  head_q     <= '0;
                  head_cnt_q <= '0;
               end else begin
                  head_q     <= {bit_val, {(DATA_W-1){1'b0}}};
                  head_cnt_q <= CNT_W'(1);
               end
            end else if (!head_full) begin
               head_q     <= head_ins;
               head_cnt_q <= head_cnt_q + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/aser_pair.sv
module aser_pair
   import aser_pkg::*;
#(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  aser_fmt_e         fmt,
   input  logic              rearm,
   input  logic              word_stb,
   input  logic [DATA_W-1:0] word,
   input  logic              word_lr,
   output logic              valid_o,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o
);

   logic              is_left;
   logic              pend_q;
   logic [DATA_W-1:0] left_hold_q;

   // The delayed framing uses the opposite word-select polarity.
   assign is_left = (fmt == FMT_I2S) ? !word_lr : word_lr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         left_hold_q <= '0;
         valid_o     <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
      end else begin
         valid_o <= 1'b0;
         if (rearm) begin
            pend_q <= 1'b0;
         end else if (word_stb) begin
            if (is_left) begin
               left_hold_q <= word;
               pend_q      <= 1'b1;
            end else begin
               pend_q <= 1'b0;
               if (pend_q) begin
                  left_o  <= left_hold_q;
                  right_o <= word;
                  valid_o <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
   import aser_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int SHORT_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        fmt_i,
   input  logic              bck_i,
   input  logic              lrck_i,
   input  logic              sdat_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o
);

   generate
      if (SHORT_W < 1 || SHORT_W > DATA_W || DATA_W < 2 || SYNC_STAGES < 0) begin : g_bad_param
         $error("audio_serial_rx: illegal width or synchronizer parameters");
      end
   endgenerate

   aser_fmt_e         fmt;
   aser_fmt_e         fmt_q;
   logic              rearm;
   logic              bit_stb;
   logic              bit_lr;
   logic              bit_val;
   logic              word_stb;
   logic [DATA_W-1:0] word;
   logic              word_lr;

   assign fmt   = aser_fmt_e'(fmt_i);
   assign rearm = (fmt != fmt_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fmt_q <= FMT_I2S;
      else         fmt_q <= fmt;
   end

   aser_front #(
      .SYNC_STAGES (SYNC_STAGES)
   ) i_front (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .bck_i   (bck_i),
      .lrck_i  (lrck_i),
      .sdat_i  (sdat_i),
      .bit_stb (bit_stb),
      .bit_lr  (bit_lr),
      .bit_val (bit_val)
   );

   aser_deser #(
      .DATA_W  (DATA_W),
      .SHORT_W (SHORT_W)
   ) i_deser (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .fmt      (fmt),
      .rearm    (rearm),
      .bit_stb  (bit_stb),
      .bit_lr   (bit_lr),
      .bit_val  (bit_val),
      .word_stb (word_stb),
      .word     (word),
      .word_lr  (word_lr)
   );

   aser_pair #(
      .DATA_W (DATA_W)
   ) i_pair (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .fmt      (fmt),
      .rearm    (rearm),
      .word_stb (word_stb),
      .word     (word),
      .word_lr  (word_lr),
      .valid_o  (valid_o),
      .left_o   (left_o),
      .right_o  (right_o)
   );

endmodule

// File: rtl/aser_rx_chk.sv
module aser_rx_chk #(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        fmt,
   input logic              word_stb,
   input logic              valid,
   input logic [DATA_W-1:0] left,
   input logic [DATA_W-1:0] right
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!valid && left == '0 && right == '0));

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R7
   words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(left) && $stable(right)));

   // R7
   strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(word_stb));

   // R8
   fmt_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fmt) |=> !valid);

endmodule

bind audio_serial_rx aser_rx_chk #(.DATA_W(DATA_W)) i_aser_rx_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .fmt      (fmt_i),
   .word_stb (word_stb),
   .valid    (valid_o),
   .left     (left_o),
   .right    (right_o)
);

// File: tb/test_audio_serial_rx.sv
`timescale 1ns/1ps
module test_audio_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt = 2'b11;
   logic        bck = 1'b0;
   logic        lrck = 1'b0;
   logic        sdat = 1'b0;
   logic        valid;
   logic [23:0] left;
   logic [23:0] right;

   int          cyc = 0;
   int          checks = 0;
   int          errs = 0;
   bit          mon_on = 1'b0;
   bit          carry = 1'b0;
   string       cur_req = "R1";

   logic [23:0] exp_l[$];
   logic [23:0] exp_r[$];
   int          exp_due[$];
   logic [23:0] last_l = '0;
   logic [23:0] last_r = '0;

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   audio_serial_rx i_audio_serial_rx (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .fmt_i   (fmt),
      .bck_i   (bck),
      .lrck_i  (lrck),
      .sdat_i  (sdat),
      .valid_o (valid),
      .left_o  (left),
      .right_o (right)
   );

   task automatic fail_line(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
      errs++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
   endtask

   // Reference comparison on every falling clock edge.
   always @(negedge clk) begin
      if (mon_on) begin
         bit due;
         due = (exp_due.size() > 0) && (exp_due[0] == cyc);
         if (valid !== due) begin
            checks++;
            fail_line({"R7 ", cur_req}, "strobe", {23'd0, valid}, {23'd0, due});
            if (due) begin
               void'(exp_l.pop_front()); void'(exp_r.pop_front()); void'(exp_due.pop_front());
            end
         end else if (due) begin
            checks += 2;
            if (left !== exp_l[0])  fail_line({cur_req, " R6"}, "left word", left, exp_l[0]);
            if (right !== exp_r[0]) fail_line({cur_req, " R6"}, "right word", right, exp_r[0]);
            void'(exp_l.pop_front()); void'(exp_r.pop_front()); void'(exp_due.pop_front());
         end
         if (valid === 1'b1) begin
            last_l = left;
            last_r = right;
         end else if (left !== last_l || right !== last_r) begin
            checks++;
            fail_line("R7", "held word changed", left ^ right, last_l ^ last_r);
            last_l = left;
            last_r = right;
         end
      end
   end

   // One slot: falling bit clock with new data, then rising bit clock.
   task automatic slot(input bit lr, input bit d, input bit push, input logic [23:0] pl, input logic [23:0] pr);
      @(negedge clk);
      bck = 1'b0; lrck = lr; sdat = d;
      repeat (3) @(negedge clk);
      bck = 1'b1;
      if (push) begin
         exp_l.push_back(pl);
         exp_r.push_back(pr);
         exp_due.push_back(cyc + 3);
      end
      repeat (2) @(negedge clk);
   endtask

   function automatic bit raw_bit(input int code, input int b, input int j, input logic [23:0] e, input bit is16);
      bit junk;
      junk = 1'($urandom);
      case (code)
         0: return (j >= b - 16) ? e[23 - (j - (b - 16))] : junk;
         1: return (j >= b - 24) ? e[23 - (j - (b - 24))] : junk;
         2: return (j < 24) ? e[23 - j] : junk;
         default: begin
            if (j < (is16 ? 16 : 24)) return e[23 - j];
            return is16 ? 1'b0 : junk;
         end
      endcase
   endfunction

   task automatic half(input int code, input int b, input bit lvl, input logic [23:0] e, input bit is16,
                       input bit push, input logic [23:0] pl, input logic [23:0] pr);
      for (int j = 0; j < b; j++) begin
         bit r;
         bit d;
         r = raw_bit(code, b, j, e, is16);
         if (code == 3) begin
            d = carry;
            carry = r;
         end else begin
            d = r;
         end
         slot(lvl, d, push && (j == 0), pl, pr);
      end
   endtask

   task automatic section(input int code, input int b, input int frames, input bit is16,
                          input bit do_reset, input string req);
      logic [23:0] wl[$];
      logic [23:0] wr[$];
      bit          lft;
      lft = (code == 3) ? 1'b0 : 1'b1;
      cur_req = req;
      fmt = 2'(code);
      if (do_reset) begin
         mon_on = 1'b0;
         rst_n = 1'b0;
         bck = 1'b0;
         lrck = ~lft;
         repeat (4) @(negedge clk);
         rst_n = 1'b1;
         last_l = '0;
         last_r = '0;
         mon_on = 1'b1;
      end
      for (int k = 0; k < frames; k++) begin
         logic [23:0] a;
         logic [23:0] c;
         a = 24'($urandom);
         c = 24'($urandom);
         if (code == 0 || is16) begin
            a[7:0] = 8'h00;
            c[7:0] = 8'h00;
         end
         wl.push_back(a);
         wr.push_back(c);
      end
      // Leading half at the right-channel level: alignment only (R8).
      half(code, b, ~lft, 24'h5A5A5A, is16, 1'b0, '0, '0);
      for (int k = 0; k < frames; k++) begin
         if (k == 0) half(code, b, lft, wl[k], is16, 1'b0, '0, '0);
         else        half(code, b, lft, wl[k], is16, 1'b1, wl[k-1], wr[k-1]);
         half(code, b, ~lft, wr[k], is16, 1'b0, '0, '0);
      end
      // Trailing half opens the boundary that completes the last frame.
      half(code, b, lft, 24'hC3C3C3, is16, 1'b1, wl[frames-1], wr[frames-1]);
      repeat (8) @(negedge clk);
      checks++;
      if (exp_due.size() != 0) fail_line({"R7 ", req}, "strobes still pending", 24'(exp_due.size()), 24'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks += 3;
      if (valid !== 1'b0)   fail_line("R1", "valid in reset", {23'd0, valid}, 24'd0);
      if (left !== 24'd0)   fail_line("R1", "left in reset", left, 24'd0);
      if (right !== 24'd0)  fail_line("R1", "right in reset", right, 24'd0);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (valid !== 1'b0 || left !== 24'd0 || right !== 24'd0)
         fail_line("R1", "after release", left | right, 24'd0);

      section(0, 16, 4, 1'b0, 1'b1, "R2");
      section(0, 32, 3, 1'b0, 1'b1, "R2");
      section(1, 32, 3, 1'b0, 1'b1, "R3");
      section(1, 24, 3, 1'b0, 1'b1, "R3");
      section(2, 32, 3, 1'b0, 1'b1, "R4");
      section(2, 24, 3, 1'b0, 1'b1, "R4");
      section(3, 32, 3, 1'b0, 1'b1, "R5");
      section(3, 24, 3, 1'b0, 1'b1, "R5");
      section(3, 16, 4, 1'b1, 1'b1, "R5");
      // Format change without reset: realignment only (R8).
      section(2, 32, 3, 1'b0, 1'b0, "R8");
      section(0, 32, 2, 1'b0, 1'b0, "R8");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL R7 watchdog expired: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule